// File: doc/BRIEF.md
# Multithreaded Barrel Issue Scheduler

This block decides, on every clock cycle, which hardware thread of an in-order multithreaded core sends its next instruction down the pipeline. It keeps a small state record for each thread context: not yet started, eligible for issue, holding one instruction in flight (a short one or one parked in a multi-cycle unit), or asleep until a numbered event fires. Because a thread never has more than one instruction in flight, the pipeline needs no hazard detection. A thread that waits on a slow shared unit or a message only removes itself from the issue pool, and the rest of the threads keep the core busy.

The pipeline reports back through two channels. A retire notification returns a thread to the pool. A park request also ends its instruction but puts the thread to sleep on an event number. An event vector, one bit per event number, wakes every thread sleeping on an asserted event. Threads start idle after reset and are enabled one at a time through a start channel. The selection among eligible threads rotates, so every eligible thread issues within one lap of the thread count.

Top module: `thread_issue_sched`

## Requirements
- R1: The block holds NUM_THREADS thread contexts (default 32), each named by its binary index on every thread id port, and all of them follow the rules below independently.
- R2: A thread that has been granted is not granted again until a retire or park request naming it arrives; a retire returns it to the eligible pool in the following cycle.
- R3: A thread whose instruction stays outstanding for any number of cycles keeps only itself out of the pool; the other eligible threads keep being granted.
- R4: A park request (park_vld, park_tid, park_evt) for a thread with an instruction in flight puts it to sleep on event park_evt; in a later cycle, wake_vec bit park_evt makes it eligible in the following cycle, while other wake_vec bits leave it asleep.
- R5: If a park request and the wake_vec bit of its own event arrive in the same cycle, the thread is eligible in the following cycle and no wakeup is lost.
- R6: issue_vld is high in every cycle in which at least one thread is eligible; the grant is formed in the same cycle from the registered thread states.
- R7: The granted thread is the first eligible one found scanning upward from the most recently granted id plus one, wrapping at NUM_THREADS; after reset the scan begins at thread 0.
- R8: When no thread is eligible, issue_vld is low and issue_tid is 0.
- R9: After reset every thread is idle and nothing is granted; start_vld with start_tid makes an idle thread eligible in the following cycle, and a start naming a thread that is not idle has no effect.
- R10: A retire or park request that names a thread with no instruction in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Enable request for an idle thread |
| start_tid | input | clog2(NUM_THREADS) | Thread to enable |
| issue_vld | output | 1 | A thread is granted this cycle |
| issue_tid | output | clog2(NUM_THREADS) | Granted thread id, 0 when none |
| done_vld | input | 1 | Retire notification |
| done_tid | input | clog2(NUM_THREADS) | Thread whose instruction retired |
| park_vld | input | 1 | Park request: instruction ends, thread sleeps |
| park_tid | input | clog2(NUM_THREADS) | Thread to park |
| park_evt | input | clog2(NUM_EVT) | Event number the thread sleeps on |
| wake_vec | input | NUM_EVT | One bit per event number; a set bit wakes its sleepers |

## Verification
The assertions assume the pipeline never sends a retire and a park for the same thread in one cycle, and that the same-cycle wake property applies only to parks of threads that really have an instruction in flight. The stimulus keeps to this by choosing retire and park targets from the bench's own record of outstanding threads and always giving them different ids. Stray retire and park requests for idle threads are sent on purpose, and the bench shows at the grant port that they change nothing.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [1:0] {
    TH_IDLE  = 2'd0,
    TH_READY = 2'd1,
    TH_BUSY  = 2'd2,
    TH_PARK  = 2'd3
  } th_state_e;

endpackage

// File: rtl/tis_thread_ctx.sv
module tis_thread_ctx
  import tis_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_hit,
  input  logic                       grant_hit,
  input  logic                       done_hit,
  input  logic                       park_hit,
  input  logic [$clog2(NUM_EVT)-1:0] park_evt,
  input  logic [NUM_EVT-1:0]         wake_vec,
  output logic                       ready_o
);

  localparam int EVT_W = $clog2(NUM_EVT);

  th_state_e        state_q, state_d;
  logic             state_en;
  logic [EVT_W-1:0] evt_q;
  logic             evt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TH_IDLE:  if (start_hit) state_d = TH_READY;
      TH_READY: if (grant_hit) state_d = TH_BUSY;
      TH_BUSY: begin
        if (park_hit)      state_d = wake_vec[park_evt] ? TH_READY : TH_PARK;
        else if (done_hit) state_d = TH_READY;
      end
      TH_PARK:  if (wake_vec[evt_q]) state_d = TH_READY;
      default:  state_d = TH_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);
  assign evt_en   = park_hit && (state_q == TH_BUSY);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TH_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else if (evt_en) begin
      evt_q <= park_evt;
    end
  end

  assign ready_o = (state_q == TH_READY);

endmodule

// File: rtl/tis_rr_pick.sv
module tis_rr_pick #(
  parameter int NUM_THREADS = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THREADS-1:0]         ready_vec,
  output logic                           gnt_vld,
  output logic [$clog2(NUM_THREADS)-1:0] gnt_tid,
  output logic [NUM_THREADS-1:0]         gnt_vec
);

  localparam int TID_W = $clog2(NUM_THREADS);

  logic [TID_W-1:0] last_q;
  logic             last_en;

  // scan upward from the thread after the last grant
  always_comb begin
    logic [TID_W-1:0] cand;
    gnt_vld = 1'b0;
    gnt_tid = '0;
    gnt_vec = '0;
    for (int i = 1; i <= NUM_THREADS; i++) begin
      cand = TID_W'((int'(last_q) + i) % NUM_THREADS);
      if (!gnt_vld && ready_vec[cand]) begin
        gnt_vld       = 1'b1;
        gnt_tid       = cand;
        gnt_vec[cand] = 1'b1;
      end
    end
  end

  assign last_en = gnt_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= TID_W'(NUM_THREADS - 1);
    end else if (last_en) begin
      last_q <= gnt_tid;
    end
  end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
  parameter int NUM_THREADS = 32,
  parameter int NUM_EVT     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] start_tid,
  output logic                           issue_vld,
  output logic [$clog2(NUM_THREADS)-1:0] issue_tid,
  input  logic                           done_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] done_tid,
  input  logic                           park_vld,
  input  logic [$clog2(NUM_THREADS)-1:0] park_tid,
  input  logic [$clog2(NUM_EVT)-1:0]     park_evt,
  input  logic [NUM_EVT-1:0]             wake_vec
);

  localparam int TID_W = $clog2(NUM_THREADS);

  logic [NUM_THREADS-1:0] ready_vec;
  logic [NUM_THREADS-1:0] gnt_vec;

  tis_rr_pick #(
    .NUM_THREADS(NUM_THREADS)
  ) pick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_vec (ready_vec),
    .gnt_vld   (issue_vld),
    .gnt_tid   (issue_tid),
    .gnt_vec   (gnt_vec)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctx
    logic start_hit, done_hit, park_hit;
    assign start_hit = start_vld && (start_tid == TID_W'(t));
    assign done_hit  = done_vld  && (done_tid  == TID_W'(t));
    assign park_hit  = park_vld  && (park_tid  == TID_W'(t));

    tis_thread_ctx #(
      .NUM_EVT(NUM_EVT)
    ) ctx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_hit (start_hit),
      .grant_hit (gnt_vec[t]),
      .done_hit  (done_hit),
      .park_hit  (park_hit),
      .park_evt  (park_evt),
      .wake_vec  (wake_vec),
      .ready_o   (ready_vec[t])
    );
  end

endmodule

// File: rtl/tis_sched_chk.sv
module tis_sched_chk #(
  parameter int NUM_THREADS = 32,
  parameter int NUM_EVT     = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           issue_vld,
  input logic [$clog2(NUM_THREADS)-1:0] issue_tid,
  input logic                           done_vld,
  input logic [$clog2(NUM_THREADS)-1:0] done_tid,
  input logic                           park_vld,
  input logic [$clog2(NUM_THREADS)-1:0] park_tid,
  input logic [$clog2(NUM_EVT)-1:0]     park_evt,
  input logic [NUM_EVT-1:0]             wake_vec,
  input logic [NUM_THREADS-1:0]         ready_vec
);

  // independent record of which threads hold an instruction
  logic [NUM_THREADS-1:0] inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= '0;
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (issue_vld && int'(issue_tid) == t)
          inflight_q[t] <= 1'b1;
        else if ((done_vld && int'(done_tid) == t) || (park_vld && int'(park_tid) == t))
          inflight_q[t] <= 1'b0;
      end
    end
  end

  a_r2_single_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> !inflight_q[issue_tid]);

  a_r2_grant_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> ready_vec[issue_tid]);

  a_r6_no_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready_vec) |-> issue_vld);

  a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ready_vec) |-> (!issue_vld && issue_tid == '0));

  a_r5_wake_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (park_vld && inflight_q[park_tid] && wake_vec[park_evt] &&
     !(done_vld && done_tid == park_tid))
    |=> ready_vec[$past(park_tid)]);

endmodule

bind thread_issue_sched tis_sched_chk #(
  .NUM_THREADS(NUM_THREADS),
  .NUM_EVT    (NUM_EVT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_vld (issue_vld),
  .issue_tid (issue_tid),
  .done_vld  (done_vld),
  .done_tid  (done_tid),
  .park_vld  (park_vld),
  .park_tid  (park_tid),
  .park_evt  (park_evt),
  .wake_vec  (wake_vec),
  .ready_vec (ready_vec)
);

// File: tb/thread_issue_sched_tb_top.sv
module thread_issue_sched_tb_top;

  localparam int NT = 4;
  localparam int NE = 4;
  localparam int TW = $clog2(NT);
  localparam int EW = $clog2(NE);

  logic          clk;
  logic          rst_n;
  logic          start_vld;
  logic [TW-1:0] start_tid;
  logic          issue_vld;
  logic [TW-1:0] issue_tid;
  logic          done_vld;
  logic [TW-1:0] done_tid;
  logic          park_vld;
  logic [TW-1:0] park_tid;
  logic [EW-1:0] park_evt;
  logic [NE-1:0] wake_vec;

  int total = 0;
  int bad   = 0;

  // bench model: 0 idle, 1 eligible, 2 in flight, 3 asleep
  int m_st  [NT];
  int m_evt [NT];
  int m_last;
  bit exp_vld;
  int exp_tid;
  bit prev_vld;
  int prev_tid;

  thread_issue_sched #(
    .NUM_THREADS(NT),
    .NUM_EVT    (NE)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_vld (start_vld),
    .start_tid (start_tid),
    .issue_vld (issue_vld),
    .issue_tid (issue_tid),
    .done_vld  (done_vld),
    .done_tid  (done_tid),
    .park_vld  (park_vld),
    .park_tid  (park_tid),
    .park_evt  (park_evt),
    .wake_vec  (wake_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic clear_inputs();
    start_vld = 1'b0; start_tid = '0;
    done_vld  = 1'b0; done_tid  = '0;
    park_vld  = 1'b0; park_tid  = '0; park_evt = '0;
    wake_vec  = '0;
  endtask

  task automatic check(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: inputs already driven after the falling edge
  task automatic tick(input string req);
    #1;
    exp_vld = 1'b0;
    exp_tid = 0;
    for (int i = 1; i <= NT; i++) begin
      int c;
      c = (m_last + i) % NT;
      if (!exp_vld && m_st[c] == 1) begin
        exp_vld = 1'b1;
        exp_tid = c;
      end
    end
    check(req, issue_vld == exp_vld,
          issue_vld ? int'(issue_tid) : -1, exp_vld ? exp_tid : -1);
    check(req, int'(issue_tid) == exp_tid, int'(issue_tid), exp_tid);
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin
      case (m_st[t])
        0: if (start_vld && int'(start_tid) == t) m_st[t] = 1;
        1: if (exp_vld && exp_tid == t) m_st[t] = 2;
        2: begin
          if (park_vld && int'(park_tid) == t) begin
            if (wake_vec[park_evt]) m_st[t] = 1;
            else begin m_st[t] = 3; m_evt[t] = int'(park_evt); end
          end else if (done_vld && int'(done_tid) == t) begin
            m_st[t] = 1;
          end
        end
        default: if (wake_vec[m_evt[t]]) m_st[t] = 1;
      endcase
    end
    if (exp_vld) m_last = exp_tid;
    prev_vld = exp_vld;
    prev_tid = exp_tid;
    @(negedge clk);
    clear_inputs();
  endtask

  // retire the previous grant every cycle except for hold_tid
  task automatic pipe(input int n, input int hold_tid, input string req);
    for (int k = 0; k < n; k++) begin
      if (prev_vld && prev_tid != hold_tid) begin
        done_vld = 1'b1;
        done_tid = TW'(prev_tid);
      end
      tick(req);
    end
  endtask

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    for (int t = 0; t < NT; t++) begin m_st[t] = 0; m_evt[t] = 0; end
    m_last   = NT - 1;
    prev_vld = 1'b0;
    prev_tid = 0;
    repeat (3) @(negedge clk);
    // R9: nothing granted while in reset
    check("R9", issue_vld == 1'b0, int'(issue_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R8: idle after reset, bubbles only
    tick("R9");
    tick("R8");

    // R10: stray retire and park for idle threads change nothing
    done_vld = 1'b1; done_tid = 2'd1;
    park_vld = 1'b1; park_tid = 2'd2; park_evt = 2'd0; wake_vec = 4'hF;
    tick("R10");
    tick("R10");
    tick("R10");

    // R9: start thread 2, it issues once, then waits (R2)
    start_vld = 1'b1; start_tid = 2'd2;
    tick("R9");
    tick("R9");
    tick("R2");
    // R9: start of a non-idle thread is ignored
    start_vld = 1'b1; start_tid = 2'd2;
    tick("R9");
    tick("R2");
    // R10: retire naming an idle thread is ignored
    done_vld = 1'b1; done_tid = 2'd0;
    tick("R10");
    tick("R10");
    // R2: retire brings thread 2 back
    done_vld = 1'b1; done_tid = 2'd2;
    tick("R2");
    tick("R2");

    // start the remaining threads while retiring
    for (int t = 0; t < NT; t++) begin
      if (t != 2) begin
        start_vld = 1'b1; start_tid = TW'(t);
        if (prev_vld) begin done_vld = 1'b1; done_tid = TW'(prev_tid); end
        tick("R9");
      end
    end

    // R6 / R7: back-to-back issue in rotating order
    pipe(16, -1, "R6");
    pipe(12, -1, "R7");

    // R3: thread 1 stays outstanding, others keep going
    pipe(14, 1, "R3");
    done_vld = 1'b1; done_tid = 2'd1;
    tick("R3");
    pipe(6, -1, "R3");

    // R4: park thread 1 on event 2
    for (int k = 0; k < 8 && !(prev_vld && prev_tid == 1); k++) pipe(1, -1, "R4");
    park_vld = 1'b1; park_tid = 2'd1; park_evt = 2'd2;
    tick("R4");
    pipe(4, -1, "R4");
    wake_vec = 4'b1011;
    if (prev_vld) begin done_vld = 1'b1; done_tid = TW'(prev_tid); end
    tick("R4");
    pipe(4, -1, "R4");
    wake_vec = 4'b0100;
    if (prev_vld) begin done_vld = 1'b1; done_tid = TW'(prev_tid); end
    tick("R4");
    pipe(6, -1, "R4");

    // R5: park thread 3 on event 1 with the wake in the same cycle
    for (int k = 0; k < 8 && !(prev_vld && prev_tid == 3); k++) pipe(1, -1, "R5");
    park_vld = 1'b1; park_tid = 2'd3; park_evt = 2'd1; wake_vec = 4'b0010;
    tick("R5");
    pipe(6, -1, "R5");

    // R1: mixed random traffic over all contexts
    for (int n = 0; n < 3000; n++) begin
      int d, p;
      if ($urandom % 4 == 0) begin
        start_vld = 1'b1; start_tid = TW'($urandom % NT);
      end
      d = $urandom % NT;
      if (m_st[d] == 2 && $urandom % 2 == 0) begin
        done_vld = 1'b1; done_tid = TW'(d);
      end
      p = $urandom % NT;
      if (p != d && m_st[p] == 2 && $urandom % 5 == 0) begin
        park_vld = 1'b1; park_tid = TW'(p); park_evt = EW'($urandom % NE);
      end
      if ($urandom % 4 == 0) wake_vec = NE'($urandom);
      tick("R1");
    end

    summary();
    $finish;
  end

endmodule